// File: doc/BRIEF.md
# Segmented Address Generator

This block forms the address for a load or store on a machine with segmented virtual addressing. It takes an already-fetched instruction word, the value of the base register, the value of an optional index register, the active access form and a bank of eight 64-bit space registers. From these it computes an offset: either the base plus a signed displacement, or the base plus a scaled index.

The block produces a 64-bit global virtual address. To build it, the offset is zero-extended and may have its top two bits stripped in wide mode. A space-register value is then ORed in, unless physical addressing is active. Address modification comes in two kinds. In pre-modify the access uses the new offset. In post-modify the access uses the old base. In both cases the new offset is returned for writeback into the base register.

All results appear on registered outputs one cycle after a valid strobe. The strobe itself is carried through to the output side. The surrounding pipeline supplies the register values, performs the access and performs the register writeback.

Top module: `seg_agu`

## Requirements
- R1: `valid_o` equals `valid_i` of the previous clock. `gva_o`, `wb_data_o`, `wb_reg_o` and `wb_en_o` reflect the inputs of that same cycle. `wb_en_o` is 0 whenever `valid_o` is 0. All outputs are 0 after reset.
- R2: A nonzero space field (instruction bits 15:14) selects the space register with that number.
- R3: A space field of 0 selects space register 4 + base[XLEN-1:XLEN-2]. This uses the unmodified base value.
- R4: Short form (`form_i`=0). The displacement is the 5-bit value at bits 20:16, read with bit 16 as the sign and bits 20:17 as the magnitude, so the value is bit16 ? mag-16 : mag. Bit 5 (m) = 0 gives no modification. m = 1 with bit 13 = 1 gives pre-modify, and m = 1 with bit 13 = 0 gives post-modify.
- R5: Indexed form (`form_i`=1). The offset is (index << s) + base, where s is bits 7:6 if bit 13 is 1 and 0 otherwise. Bit 5 = 1 gives post-modify, and bit 5 = 0 gives no modification.
- R6: Long forms. The displacement is bits 13:0 read as two's complement. With `form_i`=2 a negative displacement gives post-modify and a non-negative one gives pre-modify. With `form_i`=3 there is never any modification.
- R7: The access offset is the computed offset for no-modify and pre-modify. It is the unmodified base for post-modify.
- R8: `wb_en_o` is 1 exactly for a valid access with pre- or post-modify. `wb_data_o` is then the computed offset. `wb_reg_o` is always instruction bits 25:21.
- R9: With `wide_i`=1, bits 63:62 of the zero-extended access offset are cleared before the space value is ORed in.
- R10: With `phys_i`=1, no space value is ORed in. `gva_o` is then the (possibly wide-masked) zero-extended offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Access request strobe |
| form_i | input | 2 | Access form: 0 short, 1 indexed, 2 long modifying, 3 long plain |
| insn_i | input | 32 | Instruction word |
| base_i | input | XLEN | Base register value |
| index_i | input | XLEN | Index register value |
| space_i | input | 8*64 | Space registers, register k in bits 64k+63:64k |
| wide_i | input | 1 | Wide addressing mode |
| phys_i | input | 1 | Physical addressing mode |
| valid_o | output | 1 | Result valid |
| gva_o | output | 64 | Global virtual address |
| wb_data_o | output | XLEN | Updated base value |
| wb_reg_o | output | 5 | Base register number |
| wb_en_o | output | 1 | Base writeback enable |

## Verification
The bench builds the block with XLEN=64, so that the top two offset bits exist. This makes wide-mode masking observable and lets a masked base still steer implicit space selection. The space registers hold distinct values in bits 59:56, so every selection can be identified in the address. Long runs of mixed forms, modes and flags are compared against a behavioural model on every cycle.

// File: rtl/seg_agu_pkg.sv
package seg_agu_pkg;
  localparam int SPACE_W   = 64;
  localparam int NUM_SPACE = 8;
  localparam int SDISP_W   = 5;
  localparam int LDISP_W   = 14;

  typedef enum logic [1:0] {
    FORM_SHORT    = 2'd0,
    FORM_INDEX    = 2'd1,
    FORM_LONG_MOD = 2'd2,
    FORM_LONG     = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    MOD_NONE = 2'd0,
    MOD_PRE  = 2'd1,
    MOD_POST = 2'd2
  } mod_e;
endpackage

// File: rtl/seg_agu_decode.sv
module seg_agu_decode
  import seg_agu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  form_e             form_i,
  input  logic [31:0]       insn_i,
  output logic [XLEN-1:0]   disp_o,
  output logic [1:0]        scale_o,
  output logic              use_idx_o,
  output mod_e              mod_o
);
  logic [XLEN-1:0] sdisp, ldisp;

  // low-sign short displacement: bit 16 sign, 20:17 magnitude
  assign sdisp = {{(XLEN-SDISP_W){insn_i[16]}}, insn_i[16], insn_i[20:17]};
  assign ldisp = {{(XLEN-LDISP_W){insn_i[LDISP_W-1]}}, insn_i[LDISP_W-1:0]};

  always_comb begin
    disp_o    = '0;
    scale_o   = 2'd0;
    use_idx_o = 1'b0;
    mod_o     = MOD_NONE;
    unique case (form_i)
      FORM_SHORT: begin
        disp_o = sdisp;
        if (insn_i[5]) mod_o = insn_i[13] ? MOD_PRE : MOD_POST;
      end
      FORM_INDEX: begin
        use_idx_o = 1'b1;
        scale_o   = insn_i[13] ? insn_i[7:6] : 2'd0;
        if (insn_i[5]) mod_o = MOD_POST;
      end
      FORM_LONG_MOD: begin
        disp_o = ldisp;
        mod_o  = insn_i[LDISP_W-1] ? MOD_POST : MOD_PRE;
      end
      default: begin
        disp_o = ldisp;
      end
    endcase
  end
endmodule

// File: rtl/seg_agu_offset.sv
module seg_agu_offset
  import seg_agu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] index_i,
  input  logic [XLEN-1:0] disp_i,
  input  logic [1:0]      scale_i,
  input  logic            use_idx_i,
  input  mod_e            mod_i,
  output logic [XLEN-1:0] ofs_o,
  output logic [XLEN-1:0] acc_o
);
  logic [XLEN-1:0] addend;

  assign addend = use_idx_i ? (index_i << scale_i) : disp_i;
  assign ofs_o  = base_i + addend;
  assign acc_o  = (mod_i == MOD_POST) ? base_i : ofs_o;
endmodule

// File: rtl/seg_agu_space.sv
module seg_agu_space
  import seg_agu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [NUM_SPACE*SPACE_W-1:0] space_i,
  input  logic [1:0]                   sp_field_i,
  input  logic [1:0]                   base_hi_i,
  input  logic [XLEN-1:0]              acc_i,
  input  logic                         wide_i,
  input  logic                         phys_i,
  output logic [SPACE_W-1:0]           gva_o
);
  localparam int SEL_W = $clog2(NUM_SPACE);

  logic [SPACE_W-1:0] sr [NUM_SPACE];
  logic [SEL_W-1:0]   sel;
  logic [SPACE_W-1:0] ext;

  for (genvar k = 0; k < NUM_SPACE; k++) begin : g_unpack
    assign sr[k] = space_i[k*SPACE_W +: SPACE_W];
  end

  // implicit selection uses the unmodified base
  assign sel = (sp_field_i != 2'd0) ? SEL_W'(sp_field_i) : SEL_W'({1'b1, base_hi_i});

  always_comb begin
    ext = SPACE_W'(acc_i);
    if (wide_i) ext[SPACE_W-1 -: 2] = 2'b00;
    gva_o = phys_i ? ext : (ext | sr[sel]);
  end
endmodule

// File: rtl/seg_agu.sv
module seg_agu
  import seg_agu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [1:0]                   form_i,
  input  logic [31:0]                  insn_i,
  input  logic [XLEN-1:0]              base_i,
  input  logic [XLEN-1:0]              index_i,
  input  logic [NUM_SPACE*SPACE_W-1:0] space_i,
  input  logic                         wide_i,
  input  logic                         phys_i,
  output logic                         valid_o,
  output logic [SPACE_W-1:0]           gva_o,
  output logic [XLEN-1:0]              wb_data_o,
  output logic [4:0]                   wb_reg_o,
  output logic                         wb_en_o
);
  logic [XLEN-1:0]    disp, ofs, acc;
  logic [1:0]         scale;
  logic               use_idx;
  mod_e               mode;
  logic [SPACE_W-1:0] gva_d;

  seg_agu_decode #(.XLEN(XLEN)) u_dec (
    .form_i   (form_e'(form_i)),
    .insn_i   (insn_i),
    .disp_o   (disp),
    .scale_o  (scale),
    .use_idx_o(use_idx),
    .mod_o    (mode)
  );

  seg_agu_offset #(.XLEN(XLEN)) u_ofs (
    .base_i   (base_i),
    .index_i  (index_i),
    .disp_i   (disp),
    .scale_i  (scale),
    .use_idx_i(use_idx),
    .mod_i    (mode),
    .ofs_o    (ofs),
    .acc_o    (acc)
  );

  seg_agu_space #(.XLEN(XLEN)) u_spc (
    .space_i   (space_i),
    .sp_field_i(insn_i[15:14]),
    .base_hi_i (base_i[XLEN-1 -: 2]),
    .acc_i     (acc),
    .wide_i    (wide_i),
    .phys_i    (phys_i),
    .gva_o     (gva_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      gva_o     <= '0;
      wb_data_o <= '0;
      wb_reg_o  <= '0;
      wb_en_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      wb_en_o <= valid_i && (mode != MOD_NONE);
      if (valid_i) begin
        gva_o     <= gva_d;
        wb_data_o <= ofs;
        wb_reg_o  <= insn_i[25:21];
      end
    end
  end
endmodule

// File: rtl/seg_agu_chk.sv
module seg_agu_chk
  import seg_agu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [1:0]          form_i,
  input logic [31:0]         insn_i,
  input logic [XLEN-1:0]     base_i,
  input logic                wide_i,
  input logic                phys_i,
  input logic                valid_o,
  input logic [SPACE_W-1:0]  gva_o,
  input logic                wb_en_o
);
  p_valid_follow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i) |-> valid_o);

  p_wb_needs_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> valid_o);

  p_short_nomod_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(form_i == 2'd0 && !insn_i[5]) |-> !wb_en_o);

  p_long_mod_wb_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(form_i == 2'd2) |-> wb_en_o);

  p_post_uses_base_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(form_i == 2'd2 && insn_i[13] && phys_i && !wide_i)
      |-> gva_o[XLEN-1:0] == $past(base_i));

  p_wide_phys_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(wide_i && phys_i) |-> gva_o[SPACE_W-1 -: 2] == 2'b00);

  p_phys_no_space_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(phys_i) |-> (SPACE_W'(gva_o[XLEN-1:0]) == gva_o));
endmodule

bind seg_agu seg_agu_chk #(.XLEN(XLEN)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .form_i (form_i),
  .insn_i (insn_i),
  .base_i (base_i),
  .wide_i (wide_i),
  .phys_i (phys_i),
  .valid_o(valid_o),
  .gva_o  (gva_o),
  .wb_en_o(wb_en_o)
);

// File: tb/sim_seg_agu.sv
`timescale 1ns/1ps
module sim_seg_agu;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0;
  logic [1:0]      form_i = '0;
  logic [31:0]     insn_i = '0;
  logic [XLEN-1:0] base_i = '0, index_i = '0;
  logic [8*64-1:0] space_i;
  logic            wide_i = 1'b0, phys_i = 1'b0;
  logic            valid_o, wb_en_o;
  logic [63:0]     gva_o;
  logic [XLEN-1:0] wb_data_o;
  logic [4:0]      wb_reg_o;

  logic [63:0] sr [8];
  int checks = 0, fails = 0;

  logic            e_valid = 1'b0, e_wben = 1'b0;
  logic [63:0]     e_gva = '0;
  logic [XLEN-1:0] e_wbd = '0;
  logic [4:0]      e_reg = '0;
  string           e_tag = "R1";

  always #10 clk = ~clk;

  seg_agu #(.XLEN(XLEN)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .form_i(form_i),
    .insn_i(insn_i), .base_i(base_i), .index_i(index_i), .space_i(space_i),
    .wide_i(wide_i), .phys_i(phys_i), .valid_o(valid_o), .gva_o(gva_o),
    .wb_data_o(wb_data_o), .wb_reg_o(wb_reg_o), .wb_en_o(wb_en_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_s(input logic [1:0] sp, input logic [4:0] rb,
      input logic [4:0] f, input logic a, input logic [1:0] sz, input logic m);
    return {6'b0, rb, f, sp, a, 5'b0, sz, m, 5'b0};
  endfunction

  function automatic logic [31:0] mk_l(input logic [1:0] sp, input logic [4:0] rb,
      input logic [13:0] d);
    return {6'b0, rb, 5'b0, sp, d};
  endfunction

  // behavioural reference, from the requirements
  task automatic model();
    longint disp = 0;
    int mode = 0; // 0 none, 1 pre, 2 post
    logic [63:0] ofs, acc;
    int spn;
    case (form_i)
      2'd0: begin
        disp = insn_i[16] ? longint'(insn_i[20:17]) - 16 : longint'(insn_i[20:17]);
        if (insn_i[5]) mode = insn_i[13] ? 1 : 2;
      end
      2'd1: if (insn_i[5]) mode = 2;
      2'd2: begin
        disp = longint'($signed(insn_i[13:0]));
        mode = (disp < 0) ? 2 : 1;
      end
      default: disp = longint'($signed(insn_i[13:0]));
    endcase
    if (form_i == 2'd1)
      ofs = base_i + index_i * (64'd1 << (insn_i[13] ? int'(insn_i[7:6]) : 0));
    else
      ofs = base_i + 64'(disp);
    acc = (mode == 2) ? base_i : ofs;
    if (wide_i) acc = acc & 64'h3FFF_FFFF_FFFF_FFFF;
    spn = (insn_i[15:14] != 0) ? int'(insn_i[15:14]) : 4 + int'(base_i[63:62]);
    e_valid = valid_i;
    e_wben  = valid_i && mode != 0;
    if (valid_i) begin
      e_gva = phys_i ? acc : (acc | sr[spn]);
      e_wbd = ofs;
      e_reg = insn_i[25:21];
    end
  endtask

  task automatic compare();
    chk({e_tag, " valid R1"}, 64'(valid_o), 64'(e_valid));
    chk({e_tag, " wb_en R8"}, 64'(wb_en_o), 64'(e_wben));
    if (e_valid) begin
      chk({e_tag, " gva"}, gva_o, e_gva);
      chk({e_tag, " wb_reg R8"}, 64'(wb_reg_o), 64'(e_reg));
      if (e_wben) chk({e_tag, " wb_data R8"}, wb_data_o, e_wbd);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] f, input logic [31:0] ins,
      input logic [63:0] b, input logic [63:0] ix, input logic w, input logic p,
      input string tag);
    @(negedge clk);
    compare();
    valid_i = v; form_i = f; insn_i = ins; base_i = b; index_i = ix;
    wide_i = w; phys_i = p; e_tag = tag;
    model();
  endtask

  initial begin
    for (int k = 0; k < 8; k++) begin
      sr[k] = 64'(k + 1) << 56;
      space_i[k*64 +: 64] = sr[k];
    end
  end

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset valid", 64'(valid_o), 0);
    chk("R1 reset gva", gva_o, 0);
    chk("R1 reset wb_en", 64'(wb_en_o), 0);
    rst_n = 1'b1;
    // R2 explicit space 2, short no-modify, disp +5 (mag 5 -> bits 20:17 = 5)
    step(1, 2'd0, mk_s(2'd2, 5'd3, {4'd5, 1'b0}, 0, 0, 0), 64'h1000, 0, 0, 0, "R2");
    // R3 implicit space via base top bits 11 and 01
    step(1, 2'd0, mk_s(2'd0, 5'd4, 5'd0, 0, 0, 0), 64'hC000_0000_0000_0040, 0, 0, 0, "R3");
    step(1, 2'd0, mk_s(2'd0, 5'd4, 5'd0, 0, 0, 0), 64'h4000_0000_0000_0040, 0, 0, 0, "R3");
    // R4 negative low-sign disp -13, pre-modify then post-modify
    step(1, 2'd0, mk_s(2'd1, 5'd7, {4'd3, 1'b1}, 1, 0, 1), 64'h2000, 0, 0, 0, "R4");
    step(1, 2'd0, mk_s(2'd1, 5'd7, {4'd3, 1'b1}, 0, 0, 1), 64'h2000, 0, 0, 0, "R4 R7");
    // R5 indexed scaled by 3, then unscaled with post-modify
    step(1, 2'd1, mk_s(2'd3, 5'd9, 5'd2, 1, 2'd3, 0), 64'h100, 64'h4, 0, 0, "R5");
    step(1, 2'd1, mk_s(2'd3, 5'd9, 5'd2, 0, 2'd3, 1), 64'h100, 64'h4, 0, 0, "R5 R7");
    // R6 long modifying negative/positive, long plain
    step(1, 2'd2, mk_l(2'd1, 5'd2, 14'h3FF0), 64'h8000, 0, 0, 0, "R6 R7");
    step(1, 2'd2, mk_l(2'd1, 5'd2, 14'h0010), 64'h8000, 0, 0, 0, "R6");
    step(1, 2'd3, mk_l(2'd1, 5'd2, 14'h0010), 64'h8000, 0, 0, 0, "R6");
    // R9 wide strips 63:62 but still picks space 7 from base
    step(1, 2'd0, mk_s(2'd0, 5'd1, 5'd0, 0, 0, 0), 64'hC000_0000_0000_1234, 0, 1, 0, "R9");
    // R10 physical: no space
    step(1, 2'd3, mk_l(2'd2, 5'd1, 14'h0004), 64'hC000_0000_0000_1000, 0, 0, 1, "R10");
    step(1, 2'd2, mk_l(2'd0, 5'd1, 14'h3FFC), 64'h0000_0000_0000_1000, 0, 1, 1, "R10 R9");
    // R1 idle cycle: no writeback
    step(0, 2'd2, mk_l(2'd1, 5'd2, 14'h0010), 64'h8000, 0, 0, 0, "R1");
    for (int n = 0; n < 400; n++) begin
      step(1'($urandom), 2'($urandom), $urandom, {$urandom, $urandom},
           {$urandom, $urandom}, 1'($urandom), 1'($urandom), "R7 mix");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule